// File: doc/BRIEF.md
# I2C Master SDA Framing and Arbitration Engine

This block owns the data line of an I2C master. A separate clock generator produces the SCL waveform and hands this engine one-cycle pulses on every SCL rising and falling edge. The engine uses those pulses to frame START, repeated START, byte writes, byte reads and STOP on SDA. SDA is driven open-drain: `sda_pull` high means the line is pulled low, and `sda_in` is the line level read back.

The engine checks every bit it sends by reading the line back. When it releases SDA to send a one and finds the line low while SCL is high, another master has won the bus. The engine then stops driving at once and raises a sticky flag. It falls back to listening as a receiver, sends no STOP, and returns to the idle state only after it sees a STOP on the bus. A START issued while the engine still holds the bus becomes a repeated START. The bus is never released in between, so the controller can switch to another slave or change direction.

Software or a sequencer issues one command at a time with `cmd_valid`/`cmd_op` and waits for the `done` pulse. Each byte command must be issued while the engine holds the bus with SCL low, which is the state left after a START or a previous byte.

Top module: `i2c_arb_master`

## Requirements
- R1: A START command (`cmd_op` 2'b00), accepted while the bus is free, makes SDA fall while SCL is high. `done` pulses after the following SCL fall, and the engine then holds the bus with SDA low.
- R2: A write command (`cmd_op` 2'b01) puts the 8 data bits on SDA most significant bit first. Each bit is changed only while SCL is low. SDA is released for the 9th clock, and `rx_ack` is 1 when SDA is low at that 9th SCL rise and 0 otherwise.
- R3: A read command (`cmd_op` 2'b10) keeps SDA released for 8 clocks and captures the bits into `rx_data` most significant bit first. On the 9th clock SDA is pulled low when `ack_send` was 1 at the command, and it is released when `ack_send` was 0.
- R4: A STOP command (`cmd_op` 2'b11) pulls SDA low while SCL is low and releases it after the next SCL rise, so SDA rises while SCL is high. The bus is then free and `busy` is 0.
- R5: A START command accepted while the engine holds the bus produces a new START and never a STOP, and the engine keeps the bus afterwards.
- R6: If SDA reads low at an SCL rise during a bit the engine sends as a released one, `arb_lost` and `slave_mode` are set, `done` pulses, and `sda_pull` is 0 from that cycle on.
- R7: If SDA is already low when a START is due to be generated with SCL high, the engine reports arbitration lost in the same way and does not pull SDA.
- R8: After an arbitration loss the engine sends no STOP and never pulls SDA. It ignores all commands, and it returns to the free state once a STOP by another master appears on the bus.
- R9: `arb_lost` stays set until `arb_clr` is asserted. If a new loss and `arb_clr` happen in the same cycle, the loss wins.
- R10: `done` is a single-cycle pulse. While the bus is free, every command other than START is ignored. A command arriving while `busy` is 1 is ignored.
- R11: After reset, `sda_pull`, `busy`, `done`, `arb_lost` and `slave_mode` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_rise | input | 1 | One-cycle pulse on each SCL rising edge |
| scl_fall | input | 1 | One-cycle pulse on each SCL falling edge |
| sda_in | input | 1 | Sampled SDA line level |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 00 START, 01 write, 10 read, 11 STOP |
| cmd_data | input | DATA_W | Byte to write |
| ack_send | input | 1 | 1: acknowledge a read byte, 0: not acknowledge |
| arb_clr | input | 1 | Clears the arbitration-lost flag |
| sda_pull | output | 1 | 1 pulls SDA low (open-drain) |
| busy | output | 1 | Command in progress or listening after a loss |
| done | output | 1 | Command finished or ended by arbitration loss |
| rx_data | output | DATA_W | Last byte read |
| rx_ack | output | 1 | Acknowledge seen after the last write |
| arb_lost | output | 1 | Sticky arbitration-lost flag |
| slave_mode | output | 1 | Listening as receiver after a loss |

## Verification
Random transactions mix writes of random bytes, with the slave acknowledging or not, and reads of random bytes, with the master acknowledging or not. Some transactions also contain repeated STARTs. Comparing the wire bits captured at each SCL rise tells apart bit order, acknowledge polarity and data placement. The stop and start event counts separate a repeated START from a STOP followed by a START. The directed cases cover several arbitration situations: a competing master whose byte differs at a middle bit, and one that holds SDA low before a START. In both cases the wire must show the winner's byte, no STOP may appear from this engine, and the commands given during the loss must have no effect.

// File: rtl/i2c_arb_pkg.sv
// Shared command and state encodings for the I2C SDA framing engine.
// Assumes a 2-bit command field decoded exactly as listed below.
package i2c_arb_pkg;
    typedef enum logic [1:0] {
        OP_START = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10,
        OP_STOP  = 2'b11
    } op_e;

    typedef enum logic [2:0] {
        S_FREE,      // bus not owned, SDA released
        S_HELD,      // bus owned, SCL low, waiting for a command
        S_START,     // waiting for SCL high to place START
        S_START_LO,  // SDA low during SCL high, waiting for SCL fall
        S_BIT,       // shifting a byte plus acknowledge clock
        S_STOP,      // SDA low, waiting for SCL rise to release
        S_SLAVE      // lost arbitration, listening until STOP
    } state_e;
endpackage

// File: rtl/i2c_line_watch.sv
// Tracks the SCL level from edge pulses and flags a STOP on the bus
// (SDA rising while SCL is high). Assumes SCL is high out of reset.
module i2c_line_watch (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_rise,
    input  logic scl_fall,
    input  logic sda_in,
    output logic scl_high,
    output logic stop_seen
);
    logic sda_prev;

    // SCL level reconstructed from the edge pulses
    always_ff @(posedge clk) begin
        if (!rst_n)        scl_high <= 1'b1;
        else if (scl_rise) scl_high <= 1'b1;
        else if (scl_fall) scl_high <= 1'b0;
    end

    // previous SDA sample for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) sda_prev <= 1'b1;
        else        sda_prev <= sda_in;
    end

    assign stop_seen = scl_high && sda_in && !sda_prev;
endmodule

// File: rtl/i2c_sticky_bit.sv
// Sticky status bit: set wins over clear. Assumes single-cycle strobes.
module i2c_sticky_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);
    // hold the flag until an explicit clear
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= 1'b0;
        else if (set) q <= 1'b1;
        else if (clr) q <= 1'b0;
    end
endmodule

// File: rtl/i2c_arb_master.sv
// SDA-side framing engine of an I2C master with arbitration checking.
// Drives START / repeated START / byte write / byte read / STOP in step
// with SCL edge pulses from an external generator. Byte commands must be
// given while the bus is held with SCL low. On arbitration loss SDA is
// released and the engine listens until a STOP appears on the bus.
module i2c_arb_master #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_in,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic              ack_send,
    input  logic              arb_clr,
    output logic              sda_pull,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_ack,
    output logic              arb_lost,
    output logic              slave_mode
);
    import i2c_arb_pkg::*;

    localparam int              CNT_W = $clog2(DATA_W + 1);
    localparam int              MSB   = DATA_W - 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W);

    state_e            state;
    logic [DATA_W-1:0] shreg;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  cnt_nx;
    logic              rd_dir;
    logic              ack_q;
    logic              scl_high;
    logic              stop_seen;
    logic              own_bit;
    logic              loss_bit;
    logic              loss_start;
    logic              arb_hit;
    op_e               op;

    assign op = op_e'(cmd_op);

    i2c_line_watch u_watch (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .sda_in   (sda_in),
        .scl_high (scl_high),
        .stop_seen(stop_seen)
    );

    i2c_sticky_bit u_lost (
        .clk  (clk),
        .rst_n(rst_n),
        .set  (arb_hit),
        .clr  (arb_clr),
        .q    (arb_lost)
    );

    // which bits of the current frame this engine sends and must verify
    always_comb begin
        own_bit    = rd_dir ? (cnt == LAST) : (cnt != LAST);
        loss_bit   = (state == S_BIT) && scl_rise && own_bit && !sda_pull && !sda_in;
        loss_start = (state == S_START) && scl_high && !sda_in;
        arb_hit    = loss_bit || loss_start;
        cnt_nx     = cnt + CNT_W'(1);
    end

    assign busy       = (state != S_FREE) && (state != S_HELD);
    assign slave_mode = (state == S_SLAVE);

    // command sequencing, bit framing and arbitration reaction
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_FREE;
            sda_pull <= 1'b0;
            done     <= 1'b0;
            shreg    <= '0;
            cnt      <= '0;
            rd_dir   <= 1'b0;
            ack_q    <= 1'b0;
            rx_data  <= '0;
            rx_ack   <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                S_FREE: begin
                    if (cmd_valid && op == OP_START) state <= S_START;
                end
                S_HELD: begin
                    if (cmd_valid) begin
                        case (op)
                            OP_START: begin
                                sda_pull <= 1'b0;
                                state    <= S_START;
                            end
                            OP_WRITE: begin
                                shreg    <= cmd_data;
                                rd_dir   <= 1'b0;
                                cnt      <= '0;
                                sda_pull <= !cmd_data[MSB];
                                state    <= S_BIT;
                            end
                            OP_READ: begin
                                rd_dir   <= 1'b1;
                                ack_q    <= ack_send;
                                cnt      <= '0;
                                sda_pull <= 1'b0;
                                state    <= S_BIT;
                            end
                            default: begin
                                sda_pull <= 1'b1;
                                state    <= S_STOP;
                            end
                        endcase
                    end
                end
                S_START: begin
                    if (loss_start) begin
                        done  <= 1'b1;
                        state <= S_SLAVE;
                    end else if (scl_high) begin
                        sda_pull <= 1'b1;
                        state    <= S_START_LO;
                    end
                end
                S_START_LO: begin
                    if (scl_fall) begin
                        done  <= 1'b1;
                        state <= S_HELD;
                    end
                end
                S_BIT: begin
                    if (loss_bit) begin
                        sda_pull <= 1'b0;
                        done     <= 1'b1;
                        state    <= S_SLAVE;
                    end else if (scl_rise) begin
                        if (cnt != LAST) shreg  <= {shreg[MSB-1:0], sda_in};
                        else if (!rd_dir) rx_ack <= !sda_in;
                    end else if (scl_fall) begin
                        if (cnt == LAST) begin
                            sda_pull <= 1'b0;
                            done     <= 1'b1;
                            state    <= S_HELD;
                            if (rd_dir) rx_data <= shreg;
                        end else begin
                            cnt      <= cnt_nx;
                            sda_pull <= (cnt_nx == LAST) ? (rd_dir && ack_q)
                                                         : (!rd_dir && !shreg[MSB]);
                        end
                    end
                end
                S_STOP: begin
                    if (scl_rise) begin
                        sda_pull <= 1'b0;
                        done     <= 1'b1;
                        state    <= S_FREE;
                    end
                end
                S_SLAVE: begin
                    sda_pull <= 1'b0;
                    if (stop_seen)     state <= S_FREE;
                    else if (scl_rise) shreg <= {shreg[MSB-1:0], sda_in};
                end
                default: state <= S_FREE;
            endcase
        end
    end
endmodule

// File: rtl/i2c_arb_master_chk.sv
// Property checker for the I2C SDA framing engine, bound to the top.
// Keeps its own SCL level copy from the edge pulses.
module i2c_arb_master_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_rise,
    input logic scl_fall,
    input logic sda_in,
    input logic arb_clr,
    input logic sda_pull,
    input logic busy,
    input logic done,
    input logic arb_lost,
    input logic slave_mode
);
    logic lvl;

    // independent SCL level tracker for the checks
    always_ff @(posedge clk) begin
        if (!rst_n)        lvl <= 1'b1;
        else if (scl_rise) lvl <= 1'b1;
        else if (scl_fall) lvl <= 1'b0;
    end

    AST_START_UNDER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) && lvl |-> busy && !done); // R1
    AST_STOP_UNDER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_pull) && lvl |-> done); // R4
    AST_LOSS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arb_lost) |-> !$past(sda_in) && !$past(sda_pull)); // R6
    AST_LOSS_TO_SLAVE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arb_lost) |-> slave_mode && !sda_pull); // R6
    AST_SLAVE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        slave_mode |-> !sda_pull); // R8
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(arb_lost) && !$past(arb_clr) |-> arb_lost); // R9
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
endmodule

bind i2c_arb_master i2c_arb_master_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .sda_in    (sda_in),
    .arb_clr   (arb_clr),
    .sda_pull  (sda_pull),
    .busy      (busy),
    .done      (done),
    .arb_lost  (arb_lost),
    .slave_mode(slave_mode)
);

// File: tb/test_i2c_arb_master.sv
// Bench: models the SCL generator, a slave / competing master on SDA and a
// wire monitor; checks the engine against bench-computed expectations.
module test_i2c_arb_master;
    localparam int HALF = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_rise = 1'b0, scl_fall = 1'b0, scl_lvl = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'b00;
    logic [7:0] cmd_data = 8'h00;
    logic       ack_send = 1'b0, arb_clr = 1'b0;
    logic       other_pull = 1'b0;
    logic       sda_pull, busy, done, rx_ack, arb_lost, slave_mode, sda_line;
    logic [7:0] rx_data;

    int total = 0, bad = 0, gcnt = 0;
    int done_cnt = 0, stop_cnt = 0, start_cnt = 0, slave_drive = 0;
    logic       prev_lvl = 1'b1, prev_sda = 1'b1;
    logic [8:0] wire_bits = '0;

    always #4 clk = ~clk;

    assign sda_line = ~(sda_pull | other_pull);

    i2c_arb_master #(.DATA_W(8)) i_i2c_arb_master (
        .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .sda_in(sda_line), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_data(cmd_data), .ack_send(ack_send), .arb_clr(arb_clr),
        .sda_pull(sda_pull), .busy(busy), .done(done), .rx_data(rx_data),
        .rx_ack(rx_ack), .arb_lost(arb_lost), .slave_mode(slave_mode)
    );

    // SCL generator: toggles while the engine is busy
    always @(negedge clk) begin
        scl_rise <= 1'b0;
        scl_fall <= 1'b0;
        if (!rst_n || !busy) gcnt <= 0;
        else if (gcnt == HALF - 1) begin
            gcnt    <= 0;
            scl_lvl <= ~scl_lvl;
            if (scl_lvl) scl_fall <= 1'b1;
            else         scl_rise <= 1'b1;
        end else gcnt <= gcnt + 1;
    end

    // wire monitor: START/STOP events, bits at SCL rise, done pulses
    always @(posedge clk) begin
        prev_lvl <= scl_lvl;
        prev_sda <= sda_line;
        if (scl_lvl && prev_lvl && sda_line && !prev_sda) stop_cnt <= stop_cnt + 1;
        if (scl_lvl && prev_lvl && !sda_line && prev_sda) start_cnt <= start_cnt + 1;
        if (scl_lvl && !prev_lvl) wire_bits <= {wire_bits[7:0], sda_line};
        if (done) done_cnt <= done_cnt + 1;
        if (rst_n && slave_mode && sda_pull) slave_drive <= slave_drive + 1;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [8:0] exp_wire(input bit rd, input logic [7:0] dat,
                                            input logic [7:0] ob, input bit oth9,
                                            input bit ack);
        return rd ? {ob, !ack} : {dat & ob, !oth9};
    endfunction

    task automatic issue(input logic [1:0] op, input logic [7:0] d, input bit a);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_data = d; ack_send = a;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_done(input int d0);
        while (done_cnt == d0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic do_start(input string req);
        int d0 = done_cnt, s0 = start_cnt, p0 = stop_cnt;
        issue(2'b00, 8'h00, 1'b0);
        wait_done(d0);
        chk(start_cnt == s0 + 1, req, "START on wire", start_cnt - s0, 1);
        chk(stop_cnt == p0 && sda_pull && !busy, req, "bus held after START",
            {sda_pull, busy}, 2'b10);
    endtask

    task automatic do_stop();
        int d0 = done_cnt, p0 = stop_cnt;
        issue(2'b11, 8'h00, 1'b0);
        wait_done(d0);
        chk(stop_cnt == p0 + 1 && !busy && sda_line && scl_lvl, "R4", "STOP/free bus",
            {stop_cnt - p0, busy, sda_line, scl_lvl}, {1, 3'b011});
    endtask

    // one byte; ob is what the other party puts on SDA, oth9 its 9th-bit pull
    task automatic xfer(input bit rd, input logic [7:0] dat, input logic [7:0] ob,
                        input bit oth9, input bit ack, input bit poke);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = rd ? 2'b10 : 2'b01; cmd_data = dat; ack_send = ack;
        other_pull = !ob[7];
        @(negedge clk);
        cmd_valid = 1'b0;
        for (int k = 0; k < 9; k++) begin
            do @(posedge clk); while (!scl_fall);
            @(negedge clk);
            if (k < 7)       other_pull = !ob[6-k];
            else if (k == 7) other_pull = oth9;
            else             other_pull = 1'b0;
            if (poke && k == 3) begin
                cmd_valid = 1'b1; cmd_op = 2'b11;
                @(negedge clk);
                cmd_valid = 1'b0;
            end
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic byte_ok(input bit rd, input logic [7:0] dat, input logic [7:0] ob,
                           input bit oth9, input bit ack, input bit poke);
        int d0 = done_cnt;
        logic [8:0] ew;
        xfer(rd, dat, ob, oth9, ack, poke);
        ew = exp_wire(rd, dat, ob, oth9, ack);
        chk(done_cnt == d0 + 1, "R10", "one done per byte", done_cnt - d0, 1);
        if (rd) begin
            chk(wire_bits[8:1] == ew[8:1], "R3", "read data on wire", wire_bits[8:1], ew[8:1]);
            chk(rx_data == ob, "R3", "rx_data", rx_data, ob);
            chk(wire_bits[0] == ew[0], "R3", "master ack bit", wire_bits[0], ew[0]);
        end else begin
            chk(wire_bits[8:1] == ew[8:1], "R2", "write bits MSB first", wire_bits[8:1], ew[8:1]);
            chk(rx_ack == oth9, "R2", "rx_ack", rx_ack, oth9);
        end
    endtask

    // competing master STOP: low during SCL low, release during SCL high
    task automatic other_stop();
        while (scl_lvl) @(negedge clk);
        other_pull = 1'b1;
        while (!scl_lvl) @(negedge clk);
        repeat (2) @(negedge clk);
        other_pull = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int d0, p0, s0;
        void'($urandom(32'h1c2a));
        repeat (4) @(negedge clk);
        chk({sda_pull, busy, done, arb_lost, slave_mode} == 5'b0, "R11", "reset outputs",
            {sda_pull, busy, done, arb_lost, slave_mode}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R10: non-START commands ignored on a free bus
        d0 = done_cnt;
        issue(2'b01, 8'h55, 1'b0);
        repeat (20) @(negedge clk);
        chk(done_cnt == d0 && !busy && !sda_pull, "R10", "write on free bus ignored",
            done_cnt - d0, 0);

        // directed frame
        do_start("R1");
        byte_ok(1'b0, 8'hA5, 8'hFF, 1'b1, 1'b0, 1'b1); // poke: STOP ignored while busy (R10)
        byte_ok(1'b0, 8'h3C, 8'hFF, 1'b0, 1'b0, 1'b0);
        byte_ok(1'b1, 8'h00, 8'h96, 1'b0, 1'b1, 1'b0);
        byte_ok(1'b1, 8'h00, 8'h5A, 1'b0, 1'b0, 1'b0);
        p0 = stop_cnt;
        do_start("R5");
        chk(stop_cnt == p0, "R5", "no STOP around repeated START", stop_cnt - p0, 0);
        byte_ok(1'b0, 8'h81, 8'hFF, 1'b1, 1'b0, 1'b0);
        do_stop();

        // R6: competing master wins at bit 4 (B4 vs A7)
        do_start("R1");
        d0 = done_cnt; p0 = stop_cnt;
        xfer(1'b0, 8'hB4, 8'hA7, 1'b0, 1'b0, 1'b0);
        chk(arb_lost && slave_mode && !sda_pull, "R6", "loss state",
            {arb_lost, slave_mode, sda_pull}, 3'b110);
        chk(wire_bits[8:1] == 8'hA7, "R6", "winner byte on wire", wire_bits[8:1], 8'hA7);
        chk(done_cnt == d0 + 1, "R6", "done on loss", done_cnt - d0, 1);
        chk(stop_cnt == p0, "R8", "no STOP after loss", stop_cnt - p0, 0);
        d0 = done_cnt;
        issue(2'b01, 8'h00, 1'b0);
        repeat (15) @(negedge clk);
        chk(done_cnt == d0 && !sda_pull && slave_mode, "R8", "command ignored in slave mode",
            done_cnt - d0, 0);
        other_stop();
        chk(!slave_mode && !busy, "R8", "free after foreign STOP", {slave_mode, busy}, 0);
        chk(arb_lost, "R9", "flag kept", arb_lost, 1);
        @(negedge clk); arb_clr = 1'b1; @(negedge clk); arb_clr = 1'b0; @(negedge clk);
        chk(!arb_lost, "R9", "flag cleared", arb_lost, 0);

        // R7: SDA already low at START
        @(negedge clk); other_pull = 1'b1;
        repeat (3) @(negedge clk);
        d0 = done_cnt; s0 = start_cnt;
        issue(2'b00, 8'h00, 1'b0);
        wait_done(d0);
        chk(arb_lost && slave_mode && !sda_pull, "R7", "loss at START",
            {arb_lost, slave_mode, sda_pull}, 3'b110);
        other_stop();
        chk(!slave_mode, "R8", "free after foreign STOP", slave_mode, 0);
        @(negedge clk); arb_clr = 1'b1; @(negedge clk); arb_clr = 1'b0; @(negedge clk);
        chk(!arb_lost, "R9", "flag cleared", arb_lost, 0);

        // random transactions
        for (int t = 0; t < 12; t++) begin
            int nb;
            do_start("R1");
            nb = 1 + int'($urandom % 3);
            for (int j = 0; j < nb; j++) begin
                logic [7:0] d = 8'($urandom);
                bit rd = 1'($urandom), a = 1'($urandom);
                byte_ok(rd, d, rd ? d : 8'hFF, rd ? 1'b0 : a, a, 1'b0);
                if (($urandom % 4) == 0) begin
                    p0 = stop_cnt;
                    do_start("R5");
                    chk(stop_cnt == p0, "R5", "no STOP around repeated START", stop_cnt - p0, 0);
                end
            end
            do_stop();
        end

        chk(slave_drive == 0, "R8", "SDA never pulled in slave mode", slave_drive, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule